// File: doc/BRIEF.md
# PC-Indexed Stride Prefetcher

This block observes a stream of cache access events. Each event carries a byte address, the PC of the instruction that made it, a flag that marks instruction fetches, and a flag that marks cache misses. For data accesses it keeps a small direct-mapped history table indexed by the low PC bits. Each entry holds the full PC as a tag, the last byte address, the last stride, a 2-bit confidence counter and a one-shot mispredict flag. Training works on unmasked byte addresses, so a stride shorter than a line, such as 48 bytes with 64-byte lines, is still seen as constant. Once confidence reaches 2, the block emits up to DEGREE line-aligned prefetch addresses, one per cycle, on a valid/ready port.

Instruction fetches skip the table. They produce the DEGREE sequential lines that follow the fetched line. Three static inputs select the mode. One trains and prefetches on misses only. One trains and prefetches on data accesses only. One attaches the triggering PC to every prefetch.

Control is a two-state machine. ST_IDLE accepts one access event (acc_ready high). When that access triggers a burst, the transition "start" goes to ST_ISSUE. ST_ISSUE walks the DEGREE candidates. It holds each unaccepted prefetch and skips a candidate that falls in the same line as the one before it. The transition "done" returns to ST_IDLE after the last candidate. An access that triggers no burst stays in ST_IDLE.

Top module: `stride_pf`

## Requirements
- R1: Training uses the unmasked byte address: stride = address − stored last address (modulo 2^ADDR_W). Accesses at 0x1000, 0x1030, 0x1060, 0x1090, 0x10C0 from one PC reach confidence 2 with a 48-byte stride on the fifth access.
- R2: On a PC whose table slot holds another PC (or nothing), the slot takes the new PC and address, with stride 0, confidence 0 and the flag clear. No prefetch follows. A matching stride raises confidence (saturating at 3) and clears the flag. A data prefetch burst starts only when the updated confidence is at least 2.
- R3: One stride mismatch sets the flag and keeps the stored stride and confidence. If confidence is still at least 2, a burst is issued with the kept stride from the new address.
- R4: A second consecutive mismatch replaces the stored stride with the new one, sets confidence to 0 and clears the flag, so no burst follows.
- R5: An instruction access (acc_is_inst=1) leaves the table untouched. It issues line(addr)+k·LINE_BYTES for k = 1..DEGREE.
- R6: With cfg_miss_only=1, an access with acc_miss=0 is accepted but trains nothing and issues nothing.
- R7: With cfg_data_only=1, an instruction access is accepted but issues nothing.
- R8: With cfg_tag_pc=1, each prefetch carries the triggering PC on pf_pc with pf_pc_valid=1. Otherwise pf_pc is 0 and pf_pc_valid is 0.
- R9: Data candidate k is addr+k·stride, rounded down to a line, for k = 1..DEGREE. A candidate whose line equals the previous candidate's line (for k=1, the access's own line) is skipped and takes one cycle without pf_valid.
- R10: acc_ready is low from the cycle after a burst starts until its last candidate is accepted or skipped. An offered prefetch holds its address until pf_ready is high.
- R11: After reset, acc_ready=1, pf_valid=0 and every table slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event present |
| acc_ready | output | 1 | Block can take an access event |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_pc | input | PC_W | PC of the access |
| acc_is_inst | input | 1 | 1 = instruction fetch |
| acc_miss | input | 1 | 1 = access missed the cache |
| cfg_miss_only | input | 1 | Train/prefetch on misses only |
| cfg_data_only | input | 1 | Train/prefetch on data accesses only |
| cfg_tag_pc | input | 1 | Attach triggering PC to prefetches |
| pf_valid | output | 1 | Prefetch address offered |
| pf_ready | input | 1 | Consumer takes the prefetch |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |
| pf_pc | output | PC_W | Triggering PC, or 0 |
| pf_pc_valid | output | 1 | pf_pc is meaningful |

## Verification
Several properties are checked on every cycle:
- acc_ready stays low while a prefetch is offered.
- An offered address stays stable under backpressure.
- Every prefetch address is line-aligned.
- A burst never exceeds DEGREE handshakes.
- Consecutive issued prefetches inside a burst differ.

The confidence sequence can only be shown by the bench's scenarios: the tolerance of a single mismatch, retraining after two mismatches, slot replacement on a PC conflict, the effect of each filter bit on table state, and the exact next-line and sub-line-stride addresses.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
    typedef enum logic {ST_IDLE, ST_ISSUE} pf_state_t;
    typedef logic [1:0] conf_t;
    localparam conf_t CONF_MAX  = 2'd3;
    localparam conf_t CONF_FIRE = 2'd2;
endpackage

// File: rtl/stride_pf_table.sv
module stride_pf_table
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [PC_W-1:0]   pc,
    input  logic [ADDR_W-1:0] addr,
    output logic              go,
    output logic [ADDR_W-1:0] stride
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              v_q     [DEPTH];
    logic [PC_W-1:0]   tag_q   [DEPTH];
    logic [ADDR_W-1:0] last_q  [DEPTH];
    logic [ADDR_W-1:0] strd_q  [DEPTH];
    conf_t             conf_q  [DEPTH];
    logic              flag_q  [DEPTH];

    logic [IDX_W-1:0]  idx;
    logic              hit, match;
    logic [ADDR_W-1:0] delta, n_strd;
    conf_t             n_conf;
    logic              n_flag;

    always_comb begin
        idx   = pc[IDX_W-1:0];
        hit   = v_q[idx] && (tag_q[idx] == pc);
        delta = addr - last_q[idx];
        match = (delta == strd_q[idx]);
        n_strd = strd_q[idx];
        n_conf = conf_q[idx];
        n_flag = flag_q[idx];
        if (!hit) begin
            n_strd = '0;
            n_conf = '0;
            n_flag = 1'b0;
        end else if (match) begin
            n_conf = (conf_q[idx] == CONF_MAX) ? CONF_MAX : conf_q[idx] + 2'd1;
            n_flag = 1'b0;
        end else if (!flag_q[idx]) begin
            n_flag = 1'b1;
        end else begin
            n_strd = delta;
            n_conf = '0;
            n_flag = 1'b0;
        end
        go     = hit && (n_conf >= CONF_FIRE);
        stride = n_strd;
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic we;
        assign we = upd && (idx == IDX_W'(e));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[e]    <= 1'b0;
                tag_q[e]  <= '0;
                last_q[e] <= '0;
                strd_q[e] <= '0;
                conf_q[e] <= '0;
                flag_q[e] <= 1'b0;
            end else if (we) begin
                v_q[e]    <= 1'b1;
                tag_q[e]  <= pc;
                last_q[e] <= addr;
                strd_q[e] <= n_strd;
                conf_q[e] <= n_conf;
                flag_q[e] <= n_flag;
            end
        end
    end
endmodule

// File: rtl/stride_pf_issue.sv
module stride_pf_issue
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 64,
    parameter int DEGREE     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] step,
    input  logic [PC_W-1:0]   trig_pc,
    input  logic              tag_en,
    output logic              idle,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [PC_W-1:0]   pf_pc,
    output logic              pf_pc_valid
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int CNT_W = $clog2(DEGREE + 1);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);
    localparam logic [CNT_W-1:0]  LAST_K    = CNT_W'(DEGREE - 1);

    pf_state_t         state_q, state_d;
    logic [ADDR_W-1:0] cur_q, step_q, prev_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PC_W-1:0]   pc_q;
    logic              tag_q;
    logic [ADDR_W-1:0] cand, cand_line;
    logic              offer, advance;

    always_comb begin
        cand      = cur_q + step_q;
        cand_line = cand & LINE_MASK;
        offer     = (state_q == ST_ISSUE) && (cand_line != prev_q);
        advance   = (state_q == ST_ISSUE) && (!offer || pf_ready);
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ISSUE;
            ST_ISSUE: if (advance && cnt_q == LAST_K) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            step_q  <= '0;
            prev_q  <= '0;
            cnt_q   <= '0;
            pc_q    <= '0;
            tag_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                cur_q  <= base;
                step_q <= step;
                prev_q <= base & LINE_MASK;
                cnt_q  <= '0;
                pc_q   <= trig_pc;
                tag_q  <= tag_en;
            end else if (advance) begin
                cur_q  <= cand;
                prev_q <= cand_line;
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        idle        = (state_q == ST_IDLE);
        pf_valid    = offer;
        pf_addr     = cand_line;
        pf_pc       = tag_q ? pc_q : '0;
        pf_pc_valid = tag_q;
    end

    if (OFF_W < 1) begin : g_bad_line
        initial $error("LINE_BYTES must be at least 2");
    end
endmodule

// File: rtl/stride_pf.sv
module stride_pf
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PC_W       = 32,
    parameter int DEPTH      = 16,
    parameter int LINE_BYTES = 64,
    parameter int DEGREE     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic              acc_is_inst,
    input  logic              acc_miss,
    input  logic              cfg_miss_only,
    input  logic              cfg_data_only,
    input  logic              cfg_tag_pc,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [PC_W-1:0]   pf_pc,
    output logic              pf_pc_valid
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

    logic              idle, take, pass, train, start, go;
    logic [ADDR_W-1:0] tbl_stride, base, step;

    always_comb begin
        acc_ready = idle;
        take      = acc_valid && idle;
        pass      = !(cfg_miss_only && !acc_miss) && !(cfg_data_only && acc_is_inst);
        train     = take && pass && !acc_is_inst;
        start     = take && pass && (acc_is_inst || go);
        base      = acc_is_inst ? (acc_addr & LINE_MASK) : acc_addr;
        step      = acc_is_inst ? LINE_STEP : tbl_stride;
    end

    stride_pf_table #(.ADDR_W(ADDR_W), .PC_W(PC_W), .DEPTH(DEPTH)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (train),
        .pc     (acc_pc),
        .addr   (acc_addr),
        .go     (go),
        .stride (tbl_stride)
    );

    stride_pf_issue #(.ADDR_W(ADDR_W), .PC_W(PC_W), .LINE_BYTES(LINE_BYTES),
                      .DEGREE(DEGREE)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .base        (base),
        .step        (step),
        .trig_pc     (acc_pc),
        .tag_en      (cfg_tag_pc),
        .idle        (idle),
        .pf_valid    (pf_valid),
        .pf_ready    (pf_ready),
        .pf_addr     (pf_addr),
        .pf_pc       (pf_pc),
        .pf_pc_valid (pf_pc_valid)
    );
endmodule

// File: rtl/stride_pf_chk.sv
module stride_pf_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int DEGREE     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    int unsigned       hs_cnt;
    logic              have_last;
    logic [ADDR_W-1:0] last_addr;

    always_ff @(posedge clk) begin
        if (!rst_n || (acc_valid && acc_ready)) begin
            hs_cnt    <= 0;
            have_last <= 1'b0;
            last_addr <= '0;
        end else if (pf_valid && pf_ready) begin
            hs_cnt    <= hs_cnt + 1;
            have_last <= 1'b1;
            last_addr <= pf_addr;
        end
    end

    AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !acc_ready);                                   // R10
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr))); // R10
    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[OFF_W-1:0] == '0));                   // R9
    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        hs_cnt <= DEGREE);                                          // R5
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && have_last) |-> (pf_addr != last_addr));        // R9
endmodule

bind stride_pf stride_pf_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DEGREE(DEGREE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .pf_valid  (pf_valid),
    .pf_ready  (pf_ready),
    .pf_addr   (pf_addr)
);

// File: tb/tb_stride_pf.sv
module tb_stride_pf;
    localparam int LB = 64;
    localparam int NP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_ready;
    logic [31:0] acc_addr = '0, acc_pc = '0;
    logic        acc_is_inst = 1'b0, acc_miss = 1'b1;
    logic        cfg_miss_only = 1'b0, cfg_data_only = 1'b0, cfg_tag_pc = 1'b0;
    logic        pf_valid, pf_ready = 1'b1, pf_pc_valid;
    logic [31:0] pf_addr, pf_pc;

    int checks = 0, errors = 0;
    string cur_req = "R11";
    bit    bp_en = 1'b0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    stride_pf dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_addr(acc_addr), .acc_pc(acc_pc), .acc_is_inst(acc_is_inst),
        .acc_miss(acc_miss), .cfg_miss_only(cfg_miss_only),
        .cfg_data_only(cfg_data_only), .cfg_tag_pc(cfg_tag_pc),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
        .pf_pc(pf_pc), .pf_pc_valid(pf_pc_valid)
    );

    typedef struct { bit v; logic [31:0] a; logic [31:0] pc; bit tg; } slot_t;
    slot_t       q[$];
    logic [31:0] seen[$];

    bit          m_val [16];
    logic [31:0] m_tag [16];
    logic [31:0] m_last[16];
    logic [31:0] m_str [16];
    int          m_conf[16];
    bit          m_flag[16];

    function automatic logic [31:0] lin(input logic [31:0] a);
        return a & ~32'(LB - 1);
    endfunction

    function automatic void push_burst(input logic [31:0] cur, input logic [31:0] st,
                                       input logic [31:0] pc, input bit tg);
        logic [31:0] prev = lin(cur);
        for (int k = 1; k <= NP; k++) begin
            slot_t s;
            logic [31:0] c = lin(cur + 32'(k) * st);
            s.v = (c != prev); s.a = c; s.pc = pc; s.tg = tg;
            q.push_back(s);
            prev = c;
        end
    endfunction

    function automatic void model_access();
        int i = int'(acc_pc[3:0]);
        logic [31:0] d;
        if (cfg_miss_only && !acc_miss) return;
        if (cfg_data_only && acc_is_inst) return;
        if (acc_is_inst) begin
            push_burst(lin(acc_addr), 32'(LB), acc_pc, cfg_tag_pc);
            return;
        end
        if (!m_val[i] || m_tag[i] != acc_pc) begin
            m_val[i] = 1; m_tag[i] = acc_pc; m_last[i] = acc_addr;
            m_str[i] = 0; m_conf[i] = 0; m_flag[i] = 0;
            return;
        end
        d = acc_addr - m_last[i];
        m_last[i] = acc_addr;
        if (d == m_str[i]) begin
            if (m_conf[i] < 3) m_conf[i]++;
            m_flag[i] = 0;
        end else if (!m_flag[i]) begin
            m_flag[i] = 1;
        end else begin
            m_str[i] = d; m_conf[i] = 0; m_flag[i] = 0;
        end
        if (m_conf[i] >= 2) push_burst(acc_addr, m_str[i], acc_pc, cfg_tag_pc);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            for (int i = 0; i < 16; i++) m_val[i] = 0;
        end else if (q.size() > 0) begin
            if (!q[0].v || pf_ready) void'(q.pop_front());
        end else if (acc_valid) begin
            model_access();
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit ev;
        @(negedge clk);
        ev = (q.size() > 0) && q[0].v;
        chk(cur_req, "acc_ready", 32'(acc_ready), 32'(q.size() == 0));
        chk(cur_req, "pf_valid", 32'(pf_valid), 32'(ev));
        if (ev) begin
            chk(cur_req, "pf_addr", pf_addr, q[0].a);
            chk("R8", "pf_pc", pf_pc, q[0].tg ? q[0].pc : 32'h0);
            chk("R8", "pf_pc_valid", 32'(pf_pc_valid), 32'(q[0].tg));
        end
        pf_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
        #1;
        if (pf_valid && pf_ready) seen.push_back(pf_addr);
    endtask

    task automatic access(input logic [31:0] pc, input logic [31:0] a,
                          input bit inst, input bit miss);
        do step(); while (!acc_ready);
        acc_valid = 1; acc_pc = pc; acc_addr = a; acc_is_inst = inst; acc_miss = miss;
        step();
        acc_valid = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3 * NP + 4; i++) step();
        while (!acc_ready) step();
        step();
    endtask

    task automatic expect_seen(input string req, input logic [31:0] exp[$]);
        chk(req, "prefetch count", 32'(seen.size()), 32'(exp.size()));
        for (int i = 0; i < exp.size() && i < seen.size(); i++)
            chk(req, "prefetch addr", seen[i], exp[i]);
        seen.delete();
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R11";
        step(); step();
        seen.delete();

        // R1 R9: 48-byte stride inside 64-byte lines
        cur_req = "R1";
        access(32'h40, 32'h1000, 0, 1);
        access(32'h40, 32'h1030, 0, 1);
        access(32'h40, 32'h1060, 0, 1);
        access(32'h40, 32'h1090, 0, 1);
        drain();
        expect_seen("R2", '{});
        access(32'h40, 32'h10C0, 0, 1);
        drain();
        expect_seen("R9", '{32'h1100});
        access(32'h40, 32'h10F0, 0, 1);
        drain();
        expect_seen("R1", '{32'h1100, 32'h1140});

        // R3: single mismatch keeps stride and confidence
        cur_req = "R3";
        access(32'h40, 32'h2000, 0, 1);
        drain();
        expect_seen("R3", '{32'h2040});
        access(32'h40, 32'h2030, 0, 1);
        drain();
        expect_seen("R3", '{32'h2040, 32'h2080});

        // R4: two mismatches retrain
        cur_req = "R4";
        access(32'h40, 32'h3000, 0, 1);
        drain();
        seen.delete();
        access(32'h40, 32'h5000, 0, 1);
        access(32'h40, 32'h7000, 0, 1);
        drain();
        expect_seen("R4", '{});

        // R5 R8: instruction next-line with PC tag, under backpressure
        cur_req = "R5";
        cfg_tag_pc = 1; bp_en = 1;
        access(32'h77, 32'h8123, 1, 1);
        drain();
        expect_seen("R5", '{32'h8140, 32'h8180});
        bp_en = 0;

        // R10: backpressure on a data burst
        cur_req = "R10";
        bp_en = 1;
        access(32'h40, 32'h9000, 0, 1);
        access(32'h40, 32'h9100, 0, 1);
        access(32'h40, 32'h9200, 0, 1);
        access(32'h40, 32'h9300, 0, 1);
        access(32'h40, 32'h9400, 0, 1);
        drain();
        bp_en = 0;
        cfg_tag_pc = 0;
        seen.delete();

        // R6: hits ignored under miss-only; two off-stride hits must not retrain
        cur_req = "R6";
        cfg_miss_only = 1;
        access(32'h40, 32'hF000, 0, 0);
        access(32'h40, 32'hE000, 0, 0);
        access(32'h55, 32'h1234, 1, 0);
        access(32'h40, 32'h9500, 0, 1);
        drain();
        expect_seen("R6", '{32'h9600, 32'h9700});
        cfg_miss_only = 0;

        // R7: instruction access ignored under data-only
        cur_req = "R7";
        cfg_data_only = 1;
        access(32'h66, 32'hA000, 1, 1);
        drain();
        expect_seen("R7", '{});
        cfg_data_only = 0;

        // R2: PC conflict on slot 0 replaces the entry
        cur_req = "R2";
        access(32'h50, 32'hB000, 0, 1);
        access(32'h40, 32'h9600, 0, 1);
        access(32'h40, 32'h9700, 0, 1);
        drain();
        expect_seen("R2", '{});

        // negative stride via wraparound
        cur_req = "R1";
        access(32'h13, 32'hC400, 0, 1);
        access(32'h13, 32'hC300, 0, 1);
        access(32'h13, 32'hC200, 0, 1);
        access(32'h13, 32'hC100, 0, 1);
        access(32'h13, 32'hC000, 0, 1);
        drain();
        expect_seen("R1", '{32'hBF00, 32'hBE00});

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule